// File: doc/BRIEF.md
# Flash Program/Erase Command Controller

This block is the register front end that sits between a processor bus and an embedded flash array. Software loads a target address, up to four data words and a clock divider, then writes a command word into the control register. The controller checks the command against an unlock nibble and an erase-code byte. If the command is legal it issues a single request to the array and stays busy for a fixed number of timing ticks. It also waits for the array's completion pulse. When both are done it clears the command bits itself and raises a completion flag.

The timing tick is derived from the system clock through the 8-bit divider, which software sets so that one tick lasts 1 µs. A write lasts 2 ticks, a page erase 20 ticks and a mass erase 40 ticks. These durations are parameters. A command that fails the key or code check never reaches the array. Instead it sets an access-fault flag. Each of the two flags can drive the interrupt output through its own enable bit.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every register reads 0, the busy bit is 0, and both `flReq` and `irq` are 0.
- R2: The address register is at offset 0x00 and holds 32 bits. The divider is at 0x04 and keeps only bits 7:0, reading the upper bits as 0. The four data words are at 0x30, 0x34, 0x38 and 0x3C and read back as written. Offset 0x40 always reads 0.
- R3: Writing the control register (offset 0x08) with bit 0 = 1 and unlock field bits 31:28 = 0x2 starts a write. `flReq` is high for exactly one cycle, with `flOp` = 0 and `flAddr` set to the address register. Control bit 4 drives `flNarrow`. When it is 0 the write is 128 bits of four words at the 16-byte-aligned address. When it is 1 the write is one word, selected by address bits 3:2.
- R4: Control bit 2 requests a page erase (`flOp` = 1) and needs erase code bits 15:8 = 0x55. Control bit 1 requests a mass erase (`flOp` = 2) and needs code 0xAA.
- R5: A command is rejected when the unlock field is not 0x2, when the erase code does not match, or when more than one of bits 2:0 is set. A rejected command sets the fault flag (interrupt register 0x24, bit 1), issues no request, leaves the busy bit at 0, and leaves command bits 2:0 reading 0.
- R6: Control bit 24 reads 1 for exactly N×D+1 cycles, counted from the accepting write. N is the tick count of the operation and D is the divider value, with 0 treated as 1. This holds provided the array's done pulse arrives in time.
- R7: On completion, control bits 2:0 read 0 again, the busy bit drops, and the done flag (interrupt register bit 0) is set.
- R8: While busy, writes to the address, data and control registers are ignored, and no second request is issued.
- R9: In the interrupt register, writing 0 to bit 0 or bit 1 clears that flag and writing 1 leaves it unchanged. Bits 8 and 9 are read/write enables.
- R10: `irq` = (done AND bit 8) OR (fault AND bit 9).
- R11: An operation does not complete before `flDone` has been seen. If the pulse comes late, the busy bit falls in the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 7 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` (combinational) |
| flReq | output | 1 | One-cycle request to the flash array |
| flOp | output | 2 | Operation: 0 write, 1 page erase, 2 mass erase |
| flAddr | output | 32 | Target address |
| flData | output | 128 | The four data words, word 0 in the low bits |
| flNarrow | output | 1 | 1 = single-word write, 0 = four-word write |
| flDone | input | 1 | Completion pulse from the array |
| irq | output | 1 | Interrupt output |

## Verification
The bench looks for the following corner cases:
- Busy length. It runs busy windows with divider values 0, 1 and 3. A timer off by one tick, or one that treats a zero divider literally, gives the wrong busy length.
- Rejected commands. It issues several kinds of bad command, including a wrong key, swapped erase codes and two command bits set together. A design that checked only the key would let an erase reach the array, which the request scoreboard reports as unexpected.
- Writes while busy. During a busy window it writes the address, data and control registers. A missing lock shows up as changed readback or as a second request.
- Late done pulse. It delays the array's done pulse well past the tick count. A design that relied on its timer alone would drop busy early.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

  localparam int OFS_ADDR = 'h00;
  localparam int OFS_DIV  = 'h04;
  localparam int OFS_CTRL = 'h08;
  localparam int OFS_INTR = 'h24;
  localparam int OFS_DATA = 'h30;

  localparam logic [3:0] UNLOCK_KEY = 4'h2;
  localparam logic [7:0] CODE_PAGE  = 8'h55;
  localparam logic [7:0] CODE_MASS  = 8'hAA;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_PAGE  = 2'd1,
    OP_MASS  = 2'd2
  } flashOp_e;

  // command candidate decoded by the datapath from a control write
  typedef struct packed {
    logic       valid;
    logic [2:0] bits;
    logic [7:0] code;
    logic [3:0] unlock;
  } cmdReq_t;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;
    logic fault;
    logic finish;
  } ctlStrobe_t;

endpackage

// File: rtl/flash_cmd_timer.sv
`timescale 1ns/1ps
module flash_cmd_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clear,
  input  logic          run,
  input  logic [7:0]    clkDiv,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  logic [7:0]    divCnt;
  logic [TW-1:0] tickNum;
  logic [7:0]    divEff;

  assign divEff  = (clkDiv == 8'd0) ? 8'd1 : clkDiv;
  assign expired = (tickNum == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      tickNum <= '0;
    end else if (clear) begin
      divCnt  <= '0;
      tickNum <= '0;
    end else if (run && !expired) begin
      if (divCnt == divEff - 8'd1) begin
        divCnt  <= '0;
        tickNum <= tickNum + 1'b1;
      end else begin
        divCnt <= divCnt + 8'd1;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_ctl.sv
`timescale 1ns/1ps
module flash_cmd_ctl
  import flash_cmd_pkg::*;
#(
  parameter int DUR_WRITE = 2,
  parameter int DUR_PAGE  = 20,
  parameter int DUR_MASS  = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  cmdReq_t    cmdReq,
  input  logic [7:0] clkDiv,
  input  logic       flDone,
  output ctlStrobe_t strobe,
  output logic       pending,
  output logic       flReq,
  output logic [1:0] flOp
);

  localparam int DUR_PM  = (DUR_PAGE > DUR_MASS) ? DUR_PAGE : DUR_MASS;
  localparam int DUR_MAX = (DUR_WRITE > DUR_PM) ? DUR_WRITE : DUR_PM;
  localparam int TW      = $clog2(DUR_MAX + 1);

  flashOp_e      opSel, opQ;
  logic          legal, unlockOk, doneSeen, expired;
  logic [TW-1:0] limit;

  assign unlockOk = (cmdReq.unlock == UNLOCK_KEY);

  always_comb begin
    legal = 1'b0;
    opSel = OP_WRITE;
    case (cmdReq.bits)
      3'b001: legal = unlockOk;
      3'b010: begin
        opSel = OP_MASS;
        legal = unlockOk && (cmdReq.code == CODE_MASS);
      end
      3'b100: begin
        opSel = OP_PAGE;
        legal = unlockOk && (cmdReq.code == CODE_PAGE);
      end
      default: legal = 1'b0;
    endcase
  end

  always_comb begin
    strobe.launch = cmdReq.valid && legal;
    strobe.fault  = cmdReq.valid && !legal;
    strobe.finish = pending && expired && (doneSeen || flDone);
  end

  always_comb begin
    case (opQ)
      OP_PAGE: limit = TW'(DUR_PAGE);
      OP_MASS: limit = TW'(DUR_MASS);
      default: limit = TW'(DUR_WRITE);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= 1'b0;
      opQ      <= OP_WRITE;
      flReq    <= 1'b0;
      doneSeen <= 1'b0;
    end else begin
      flReq <= strobe.launch;
      if (strobe.launch) begin
        pending  <= 1'b1;
        opQ      <= opSel;
        doneSeen <= 1'b0;
      end else if (strobe.finish) begin
        pending <= 1'b0;
      end else if (pending && flDone) begin
        doneSeen <= 1'b1;
      end
    end
  end

  assign flOp = opQ;

  flash_cmd_timer #(.TW(TW)) uTimer (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (strobe.launch),
    .run     (pending),
    .clkDiv  (clkDiv),
    .limit   (limit),
    .expired (expired)
  );

endmodule

// File: rtl/flash_cmd_regs.sv
`timescale 1ns/1ps
module flash_cmd_regs
  import flash_cmd_pkg::*;
#(
  parameter int REG_AW    = 7,
  parameter int NUM_WORDS = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWr,
  input  logic [REG_AW-1:0]       regAddr,
  input  logic [31:0]             regWdata,
  output logic [31:0]             regRdata,
  input  logic                    pending,
  input  ctlStrobe_t              strobe,
  output cmdReq_t                 cmdReq,
  output logic [7:0]              clkDiv,
  output logic [31:0]             flAddr,
  output logic [32*NUM_WORDS-1:0] flData,
  output logic                    flNarrow,
  output logic                    irq
);

  localparam logic [REG_AW-1:0] A_ADDR = REG_AW'(OFS_ADDR);
  localparam logic [REG_AW-1:0] A_DIV  = REG_AW'(OFS_DIV);
  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(OFS_CTRL);
  localparam logic [REG_AW-1:0] A_INTR = REG_AW'(OFS_INTR);

  logic [31:0] addrQ;
  logic [7:0]  divQ;
  logic [2:0]  cmdQ;
  logic        widthQ;
  logic [7:0]  codeQ;
  logic [3:0]  unlockQ;
  logic        doneQ, faultQ, doneEnQ, faultEnQ;
  logic        wrOpen;

  assign wrOpen = regWr && !pending;

  always_comb begin
    cmdReq.valid  = wrOpen && (regAddr == A_CTRL) && (regWdata[2:0] != 3'b000);
    cmdReq.bits   = regWdata[2:0];
    cmdReq.code   = regWdata[15:8];
    cmdReq.unlock = regWdata[31:28];
  end

  // data words
  for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
    logic [31:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wordQ <= '0;
      else if (wrOpen && regAddr == REG_AW'(OFS_DATA + 4*w)) wordQ <= regWdata;
    end
    assign flData[w*32 +: 32] = wordQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      divQ     <= '0;
      cmdQ     <= '0;
      widthQ   <= 1'b0;
      codeQ    <= '0;
      unlockQ  <= '0;
      doneQ    <= 1'b0;
      faultQ   <= 1'b0;
      doneEnQ  <= 1'b0;
      faultEnQ <= 1'b0;
    end else begin
      if (wrOpen && regAddr == A_ADDR) addrQ <= regWdata;
      if (regWr && regAddr == A_DIV) divQ <= regWdata[7:0];
      if (wrOpen && regAddr == A_CTRL) begin
        widthQ  <= regWdata[4];
        codeQ   <= regWdata[15:8];
        unlockQ <= regWdata[31:28];
      end
      if (strobe.launch) cmdQ <= regWdata[2:0];
      if (strobe.finish) cmdQ <= '0;
      if (regWr && regAddr == A_INTR) begin
        doneEnQ  <= regWdata[8];
        faultEnQ <= regWdata[9];
        doneQ    <= doneQ & regWdata[0];
        faultQ   <= faultQ & regWdata[1];
      end
      if (strobe.finish) doneQ  <= 1'b1;
      if (strobe.fault)  faultQ <= 1'b1;
    end
  end

  always_comb begin
    case (regAddr)
      A_ADDR:  regRdata = addrQ;
      A_DIV:   regRdata = {24'b0, divQ};
      A_CTRL:  regRdata = {unlockQ, 3'b0, pending, 8'b0, codeQ, 3'b0, widthQ, 1'b0, cmdQ};
      A_INTR:  regRdata = {22'b0, faultEnQ, doneEnQ, 6'b0, faultQ, doneQ};
      default: regRdata = '0;
    endcase
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (regAddr == REG_AW'(OFS_DATA + 4*w)) regRdata = flData[w*32 +: 32];
    end
  end

  assign clkDiv   = divQ;
  assign flAddr   = addrQ;
  assign flNarrow = widthQ;
  assign irq      = (doneQ & doneEnQ) | (faultQ & faultEnQ);

endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int REG_AW    = 7,
  parameter int NUM_WORDS = 4,
  parameter int DUR_WRITE = 2,
  parameter int DUR_PAGE  = 20,
  parameter int DUR_MASS  = 40
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWr,
  input  logic [REG_AW-1:0]       regAddr,
  input  logic [31:0]             regWdata,
  output logic [31:0]             regRdata,
  output logic                    flReq,
  output logic [1:0]              flOp,
  output logic [31:0]             flAddr,
  output logic [32*NUM_WORDS-1:0] flData,
  output logic                    flNarrow,
  input  logic                    flDone,
  output logic                    irq
);

  cmdReq_t    cmdReq;
  ctlStrobe_t strobe;
  logic       pending;
  logic [7:0] clkDiv;

  flash_cmd_regs #(.REG_AW(REG_AW), .NUM_WORDS(NUM_WORDS)) uRegs (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .pending  (pending),
    .strobe   (strobe),
    .cmdReq   (cmdReq),
    .clkDiv   (clkDiv),
    .flAddr   (flAddr),
    .flData   (flData),
    .flNarrow (flNarrow),
    .irq      (irq)
  );

  flash_cmd_ctl #(.DUR_WRITE(DUR_WRITE), .DUR_PAGE(DUR_PAGE), .DUR_MASS(DUR_MASS)) uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdReq  (cmdReq),
    .clkDiv  (clkDiv),
    .flDone  (flDone),
    .strobe  (strobe),
    .pending (pending),
    .flReq   (flReq),
    .flOp    (flOp)
  );

endmodule

// File: rtl/flash_cmd_chk.sv
`timescale 1ns/1ps
module flash_cmd_chk
  import flash_cmd_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       flReq,
  input logic       pending,
  input ctlStrobe_t strobe
);

  // R3
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    flReq |=> !flReq);

  // R3
  launch_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |=> flReq);

  // R6
  req_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    flReq |-> pending);

  // R5
  fault_noreq_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fault |=> (!flReq && !pending));

  // R7
  finish_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> !pending);

endmodule

bind flash_cmd_ctrl flash_cmd_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .flReq   (flReq),
  .pending (pending),
  .strobe  (strobe)
);

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;

  localparam logic [6:0] A_ADDR = 7'h00, A_DIV = 7'h04, A_CTRL = 7'h08,
                         A_INTR = 7'h24, A_DATA = 7'h30, A_KEY = 7'h40;

  typedef struct packed {
    logic [1:0]   op;
    logic [31:0]  addr;
    logic         narrow;
    logic [127:0] data;
  } req_t;

  logic         clk, rstN, regWr, flReq, flNarrow, flDone, irq;
  logic [6:0]   regAddr;
  logic [31:0]  regWdata, regRdata, flAddr;
  logic [1:0]   flOp;
  logic [127:0] flData;

  int checks = 0, fails = 0, doneDelay = 0;
  bit finished = 0;
  req_t expQ[$];
  logic [31:0] mem [64];
  logic [31:0] shAddr;
  logic [31:0] shData [4];

  flash_cmd_ctrl u_flash_cmd_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .flReq(flReq), .flOp(flOp),
    .flAddr(flAddr), .flData(flData), .flNarrow(flNarrow), .flDone(flDone),
    .irq(irq)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [6:0] a, logic [31:0] d);
    regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 0;
  endtask

  task automatic rdReg(logic [6:0] a, output logic [31:0] v);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic rdChk(string tag, logic [6:0] a, logic [31:0] exp);
    logic [31:0] v;
    rdReg(a, v);
    chk(tag, v, exp);
  endtask

  // driver: push the expected array request, then issue the command
  task automatic launch(logic [31:0] ctrl, logic [1:0] op);
    req_t r;
    r.op = op; r.addr = shAddr; r.narrow = ctrl[4];
    r.data = {shData[3], shData[2], shData[1], shData[0]};
    expQ.push_back(r);
    wrReg(A_CTRL, ctrl);
  endtask

  task automatic waitIdle(output int n);
    logic [31:0] v;
    n = 0;
    rdReg(A_CTRL, v);
    while (v[24]) begin
      n++;
      @(negedge clk);
      rdReg(A_CTRL, v);
    end
  endtask

  task automatic badCmd(logic [31:0] ctrl);
    wrReg(A_CTRL, ctrl);
    rdChk("R5 ctrl after reject", A_CTRL, ctrl & 32'hFFFF_FFF8);
    rdChk("R5 fault flag set", A_INTR, 32'h0000_0202);
    chk("R10 irq on fault", irq, 1'b1);
    wrReg(A_INTR, 32'h0000_0200);
    rdChk("R9 fault cleared", A_INTR, 32'h0000_0200);
    chk("R10 irq after clear", irq, 1'b0);
  endtask

  // monitor: behavioural array plus scoreboard compare
  initial begin
    flDone = 0;
    forever begin
      @(negedge clk);
      if (rstN && flReq) begin
        if (expQ.size() == 0) begin
          chk("R5/R8 unexpected request", 1'b1, 1'b0);
        end else begin
          req_t e;
          e = expQ.pop_front();
          chk("R3/R4 op", flOp, e.op);
          chk("R3 addr", flAddr, e.addr);
          chk("R3 width", flNarrow, e.narrow);
          chk("R3 data", flData, e.data);
        end
        case (flOp)
          2'd0: if (flNarrow) mem[flAddr[7:2]] = flData[flAddr[3:2]*32 +: 32];
                else for (int i = 0; i < 4; i++) mem[int'(flAddr[7:4])*4 + i] = flData[i*32 +: 32];
          2'd1: for (int i = 0; i < 16; i++) mem[int'(flAddr[7:6])*16 + i] = 32'hFFFF_FFFF;
          default: for (int i = 0; i < 64; i++) mem[i] = 32'hFFFF_FFFF;
        endcase
        repeat (doneDelay) @(negedge clk);
        flDone = 1;
        @(negedge clk);
        flDone = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R6 watchdog: actual busy expected idle");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    regWr = 0; regAddr = '0; regWdata = '0; rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1
    rdChk("R1 addr reset", A_ADDR, 0);
    rdChk("R1 div reset", A_DIV, 0);
    rdChk("R1 ctrl reset", A_CTRL, 0);
    rdChk("R1 intr reset", A_INTR, 0);
    chk("R1 irq reset", irq, 1'b0);
    chk("R1 req reset", flReq, 1'b0);

    // R2
    wrReg(A_ADDR, 32'h1234_5678); rdChk("R2 addr", A_ADDR, 32'h1234_5678);
    wrReg(A_DIV, 32'hFFFF_FF03);  rdChk("R2 div", A_DIV, 32'h0000_0003);
    for (int i = 0; i < 4; i++) begin
      shData[i] = 32'hA5A5_0000 + 32'(i * 32'h1111);
      wrReg(A_DATA + 7'(4*i), shData[i]);
      rdChk("R2 data word", A_DATA + 7'(4*i), shData[i]);
    end
    wrReg(A_KEY, 32'h3A7F_0001); rdChk("R2 key reads zero", A_KEY, 0);

    // R3/R6/R7 wide write, divider 3
    shAddr = 32'h10; wrReg(A_ADDR, shAddr);
    launch(32'h2000_0001, 2'd0);
    waitIdle(n);
    chk("R6 busy div3 write", n, 7);
    rdChk("R7 cmd cleared", A_CTRL, 32'h2000_0000);
    rdChk("R7 done set", A_INTR, 32'h0000_0001);
    for (int i = 0; i < 4; i++) chk("R3 wide write mem", mem[4+i], shData[i]);

    // R9
    wrReg(A_INTR, 32'h0000_0002);
    rdChk("R9 done cleared, fault not set", A_INTR, 0);

    // R3/R6/R10 narrow write, divider 0
    wrReg(A_INTR, 32'h0000_0100);
    wrReg(A_DIV, 0);
    shAddr = 32'h24; wrReg(A_ADDR, shAddr);
    launch(32'h2000_0011, 2'd0);
    waitIdle(n);
    chk("R6 busy div0 write", n, 3);
    chk("R3 narrow write mem", mem[9], shData[1]);
    chk("R3 narrow leaves neighbour", mem[8], 32'h0);
    chk("R10 irq on done", irq, 1'b1);
    wrReg(A_INTR, 32'h0000_0100);
    chk("R10 irq after clear", irq, 1'b0);

    // R4 page erase
    wrReg(A_DIV, 1);
    shAddr = 32'h40; wrReg(A_ADDR, shAddr);
    launch(32'h2000_5504, 2'd1);
    waitIdle(n);
    chk("R6 busy page erase", n, 21);
    chk("R4 page erased", mem[20], 32'hFFFF_FFFF);
    chk("R4 other page kept", mem[4], shData[0]);
    rdChk("R7 page cmd cleared", A_CTRL, 32'h2000_5500);

    // R5 rejects
    wrReg(A_INTR, 32'h0000_0200);
    badCmd(32'h3000_0001);
    badCmd(32'h2000_AA04);
    badCmd(32'h2000_5502);
    badCmd(32'h2000_0003);
    badCmd(32'h0000_5504);
    chk("R5 page kept after rejects", mem[4], shData[0]);

    // R4 mass erase
    launch(32'h2000_AA02, 2'd2);
    waitIdle(n);
    chk("R6 busy mass erase", n, 41);
    chk("R4 mass erased low", mem[0], 32'hFFFF_FFFF);
    chk("R4 mass erased high", mem[63], 32'hFFFF_FFFF);

    // R8 writes while busy
    wrReg(A_INTR, 0);
    wrReg(A_DIV, 2);
    shAddr = 32'h30; wrReg(A_ADDR, shAddr);
    launch(32'h2000_5504, 2'd1);
    wrReg(A_ADDR, 32'h55);
    wrReg(A_DATA, 32'hDEAD_BEEF);
    wrReg(A_CTRL, 32'h2000_0011);
    waitIdle(n);
    rdChk("R8 addr locked", A_ADDR, shAddr);
    rdChk("R8 data locked", A_DATA, shData[0]);
    rdChk("R8 ctrl locked", A_CTRL, 32'h2000_5500);
    rdChk("R8 no fault while busy", A_INTR, 32'h0000_0001);

    // R11 late done
    wrReg(A_DIV, 1);
    doneDelay = 10;
    launch(32'h2000_0011, 2'd0);
    waitIdle(n);
    chk("R11 busy waits for done", n, 11);
    doneDelay = 0;
    chk("R11 late write mem", mem[12], shData[0]);

    repeat (5) @(negedge clk);
    chk("R3 all requests seen", expQ.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule